// File: doc/BRIEF.md
# Endpoint Buffer DMA Handshake Controller

This block moves the payload of one endpoint packet between a packet buffer and an external DMA engine. The DMA engine works in single-address mode. Each byte is paced only by a request output and by four active-low inputs: acknowledge, read strobe, write strobe and end-of-transfer. A local CPU writes three control bits: an enable, a direction and a burst/single-cycle pacing choice. It then watches the enable readback and two sticky status flags that tell it whether the transfer finished by count or was cut short by end-of-transfer.

The buffer keeps a two-byte header ahead of the payload. Address 0 holds a status byte and address 1 holds the payload length in bytes. Payload byte k sits at address 2+k. The header never appears on the DMA stream. In the read direction, the length is fetched from the header and the first strobe delivers payload byte 0. In the write direction, the header is filled in after the stream stops: the byte count goes to address 1, and a status value with the full bit set goes to address 0.

All four handshake inputs pass through a synchronizer chain. A byte moves on the detected release (rising edge) of the active strobe while acknowledge is low. A strobe held low for many clocks therefore still moves a single byte.

Top module: `epdma_hs`

## Requirements
- R1: After reset, `dreq`, `en_o`, `done_o` and `term_o` are 0. A CPU write with `reg_we`=1 and `reg_en`=1 while idle sets `en_o`, and `dreq` then rises. `dreq` is never 1 while `en_o` is 0.
- R2: `reg_dir`=1 selects the write direction, where bytes on `dma_din` go into the buffer. `reg_dir`=0 selects the read direction, where buffer bytes appear on `dma_dout`. The direction is latched when the transfer is enabled.
- R3: Single-cycle pacing (`reg_burst`=0) takes `dreq` low one clock after the synchronized acknowledge is seen low. `dreq` rises again only after acknowledge has returned high.
- R4: Burst pacing (`reg_burst`=1) keeps `dreq` high through successive acknowledge and strobe cycles, until the transfer ends.
- R5: An end-of-transfer is taken only when `eot_n`, `dack_n` and either `rd_n` or `wr_n` are all low at once. It takes `dreq` low within four clocks of those inputs. The byte under that strobe still moves. After it moves, `en_o` clears and `term_o` sets. `eot_n` low with `dack_n` high has no effect.
- R6: A CPU write with `reg_we`=1 and `reg_en`=0 stops the transfer. `dreq` and `en_o` are 0 after the next clock edge.
- R7: In the read direction, the length is taken from buffer address 1, and the first strobe returns the byte at address 2. Once that many bytes have moved, `dreq` drops, `en_o` clears and `done_o` sets. A length of 0 completes with `done_o` and no request.
- R8: In the write direction, byte k is stored at address 2+k. When the transfer ends for any reason, the count is written to address 1 and then 8'h01 (bit 0 = buffer full) is written to address 0.
- R9: Each strobe moves exactly one byte, however long the strobe is held. `byte_cnt` counts the bytes moved in the current transfer.
- R10: `done_o` and `term_o` are never both 1, and an accepted enable clears both.
- R11: A write transfer stops by itself after DEPTH-2 bytes, with `done_o` set. `byte_cnt` never exceeds DEPTH-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | CPU control write strobe |
| reg_en | input | 1 | Enable value written |
| reg_dir | input | 1 | 1 = into buffer, 0 = out of buffer |
| reg_burst | input | 1 | 1 = burst pacing, 0 = single-cycle |
| en_o | output | 1 | Enable readback |
| done_o | output | 1 | Sticky: ended by count |
| term_o | output | 1 | Sticky: ended by end-of-transfer |
| byte_cnt | output | AW | Bytes moved in this transfer |
| dreq | output | 1 | DMA request |
| dack_n | input | 1 | DMA acknowledge, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| eot_n | input | 1 | End of transfer, active low |
| dma_din | input | DW | Byte from the DMA side |
| dma_dout | output | DW | Byte to the DMA side |
| buf_addr | output | AW | Buffer address |
| buf_we | output | 1 | Buffer write enable |
| buf_wdata | output | DW | Buffer write data |
| buf_rdata | input | DW | Buffer read data at `buf_addr` |

## Verification
A corrupted byte counter shows up at the ports within one strobe. It appears as the wrong byte on `dma_dout`, as a payload byte stored at the wrong address, or as a count in header byte 1 that differs from the number of strobes given. A stuck or wrongly decoded state shows up within a few clocks: as a request that does not fall after an acknowledge or end-of-transfer, as a request that stays low in burst pacing, or as header bytes that are missing or placed wrongly once the transfer ends. The flag logic is judged by which of the two status flags is set after each way of ending a transfer.

// File: rtl/epdma_pkg.sv
package epdma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_XFER,
      ST_WLEN,
      ST_WSTAT
   } epdma_st_e;

   localparam int HDR_STAT_OFS = 0;
   localparam int HDR_LEN_OFS  = 1;
   localparam int PAYLOAD_OFS  = 2;
   localparam int STAT_FULL_BIT = 0;
endpackage

// File: rtl/epdma_sync.sv
module epdma_sync #(
   parameter int          W      = 4,
   parameter int          STAGES = 2,
   parameter logic [W-1:0] INIT  = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("epdma_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= INIT;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/epdma_ctrl.sv
module epdma_ctrl
   import epdma_pkg::*;
#(
   parameter int AW  = 6,
   parameter int DW  = 8,
   parameter int CAP = 62
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic          reg_en,
   input  logic          reg_dir,
   input  logic          reg_burst,
   input  logic          dack_s,
   input  logic          rd_s,
   input  logic          wr_s,
   input  logic          eot_s,
   input  logic [DW-1:0] hdr_len,
   output epdma_st_e     st,
   output logic [AW-1:0] cnt,
   output logic          dir_q,
   output logic          burst_q,
   output logic          en_q,
   output logic          dreq_q,
   output logic          done_q,
   output logic          term_q,
   output logic          mv,
   output logic          eot_hit
);
   localparam logic [AW-1:0] CAP_A = AW'(CAP);
   localparam logic [DW-1:0] CAP_D = DW'(CAP);

   epdma_st_e     st_n;
   logic [AW-1:0] len_q;
   logic [AW-1:0] len_c;
   logic [AW-1:0] lim;
   logic [AW-1:0] cnt_nx;
   logic          strb_s, strb_prev;
   logic          eot_pend;
   logic          in_x, stop, start, fin, endx, len0;

   assign stop   = reg_we && !reg_en;
   assign start  = reg_we && reg_en && (st == ST_IDLE) && !en_q;
   assign in_x   = (st == ST_XFER);
   assign strb_s = dir_q ? wr_s : rd_s;

   assign eot_hit = in_x && !eot_s && !dack_s && (!rd_s || !wr_s);
   assign mv      = in_x && strb_s && !strb_prev && !dack_s;

   assign cnt_nx = cnt + 1'b1;
   assign lim    = dir_q ? CAP_A : len_q;
   assign fin    = mv && (cnt_nx == lim);
   assign endx   = in_x && (stop || fin || (mv && eot_pend));

   assign len_c  = (hdr_len > CAP_D) ? CAP_A : hdr_len[AW-1:0];
   assign len0   = (st == ST_HDR) && (hdr_len == '0);

   always_comb begin
      st_n = st;
      unique case (st)
         ST_IDLE:  if (en_q && !stop) st_n = dir_q ? ST_XFER : ST_HDR;
         ST_HDR:   if (stop || len0) st_n = ST_IDLE;
                   else st_n = ST_XFER;
         ST_XFER:  if (endx) st_n = dir_q ? ST_WLEN : ST_IDLE;
         ST_WLEN:  st_n = ST_WSTAT;
         ST_WSTAT: st_n = ST_IDLE;
         default:  st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         len_q     <= '0;
         dir_q     <= 1'b0;
         burst_q   <= 1'b0;
         en_q      <= 1'b0;
         dreq_q    <= 1'b0;
         done_q    <= 1'b0;
         term_q    <= 1'b0;
         eot_pend  <= 1'b0;
         strb_prev <= 1'b1;
      end else begin
         st        <= st_n;
         strb_prev <= strb_s;
         dreq_q    <= in_x && !endx && !eot_pend && !eot_hit && !stop
                      && (burst_q || dack_s);

         if (start) begin
            en_q    <= 1'b1;
            dir_q   <= reg_dir;
            burst_q <= reg_burst;
            done_q  <= 1'b0;
            term_q  <= 1'b0;
            cnt     <= '0;
         end else begin
            if (stop || len0 || endx) en_q <= 1'b0;
            if (mv) cnt <= cnt_nx;
            if ((len0 && !stop) || (fin && !eot_pend && !stop)) done_q <= 1'b1;
            if (mv && eot_pend && !stop) term_q <= 1'b1;
         end

         if (st == ST_HDR) len_q <= len_c;

         if (start || endx) eot_pend <= 1'b0;
         else if (eot_hit)  eot_pend <= 1'b1;
      end
   end
endmodule

// File: rtl/epdma_bufport.sv
module epdma_bufport
   import epdma_pkg::*;
#(
   parameter int AW       = 6,
   parameter int DW       = 8,
   parameter bit DOUT_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  epdma_st_e     st,
   input  logic [AW-1:0] cnt,
   input  logic          dir_q,
   input  logic          mv,
   input  logic [DW-1:0] dma_din,
   input  logic [DW-1:0] buf_rdata,
   output logic [AW-1:0] buf_addr,
   output logic          buf_we,
   output logic [DW-1:0] buf_wdata,
   output logic [DW-1:0] dma_dout
);
   localparam logic [AW-1:0] A_STAT = AW'(HDR_STAT_OFS);
   localparam logic [AW-1:0] A_LEN  = AW'(HDR_LEN_OFS);
   localparam logic [AW-1:0] A_DATA = AW'(PAYLOAD_OFS);
   localparam logic [DW-1:0] STAT_V = DW'(1) << STAT_FULL_BIT;

   logic [DW-1:0] dout_c;

   always_comb begin
      buf_addr  = A_DATA + cnt;
      buf_we    = 1'b0;
      buf_wdata = dma_din;
      unique case (st)
         ST_HDR:   buf_addr = A_LEN;
         ST_XFER:  buf_we   = dir_q && mv;
         ST_WLEN:  begin
            buf_addr  = A_LEN;
            buf_we    = 1'b1;
            buf_wdata = DW'(cnt);
         end
         ST_WSTAT: begin
            buf_addr  = A_STAT;
            buf_we    = 1'b1;
            buf_wdata = STAT_V;
         end
         default:  buf_addr = A_DATA + cnt;
      endcase
   end

   assign dout_c = ((st == ST_XFER) && !dir_q) ? buf_rdata : '0;

   if (DOUT_REG) begin : g_dout_reg
      logic [DW-1:0] dout_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dout_q <= '0;
         else        dout_q <= dout_c;
      end
      assign dma_dout = dout_q;
   end else begin : g_dout_comb
      assign dma_dout = dout_c;
   end
endmodule

// File: rtl/epdma_hs.sv
module epdma_hs
   import epdma_pkg::*;
#(
   parameter int DEPTH       = 64,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit DOUT_REG    = 1'b0,
   localparam int AW  = $clog2(DEPTH),
   localparam int CAP = DEPTH - PAYLOAD_OFS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic          reg_en,
   input  logic          reg_dir,
   input  logic          reg_burst,
   output logic          en_o,
   output logic          done_o,
   output logic          term_o,
   output logic [AW-1:0] byte_cnt,
   output logic          dreq,
   input  logic          dack_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic          eot_n,
   input  logic [DW-1:0] dma_din,
   output logic [DW-1:0] dma_dout,
   output logic [AW-1:0] buf_addr,
   output logic          buf_we,
   output logic [DW-1:0] buf_wdata,
   input  logic [DW-1:0] buf_rdata
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("epdma_hs: DEPTH must be a power of two, at least 4");
   end
   if (CAP >= (2 ** DW)) begin : g_bad_dw
      $error("epdma_hs: payload capacity does not fit the length byte");
   end

   logic [3:0] hs_s;
   logic       dack_s, rd_s, wr_s, eot_s;
   epdma_st_e  st;
   logic       dir_q, burst_q, mv, eot_hit;

   epdma_sync #(.W(4), .STAGES(SYNC_STAGES), .INIT(4'hF)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({dack_n, rd_n, wr_n, eot_n}),
      .q     (hs_s)
   );
   assign {dack_s, rd_s, wr_s, eot_s} = hs_s;

   epdma_ctrl #(.AW(AW), .DW(DW), .CAP(CAP)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_en    (reg_en),
      .reg_dir   (reg_dir),
      .reg_burst (reg_burst),
      .dack_s    (dack_s),
      .rd_s      (rd_s),
      .wr_s      (wr_s),
      .eot_s     (eot_s),
      .hdr_len   (buf_rdata),
      .st        (st),
      .cnt       (byte_cnt),
      .dir_q     (dir_q),
      .burst_q   (burst_q),
      .en_q      (en_o),
      .dreq_q    (dreq),
      .done_q    (done_o),
      .term_q    (term_o),
      .mv        (mv),
      .eot_hit   (eot_hit)
   );

   epdma_bufport #(.AW(AW), .DW(DW), .DOUT_REG(DOUT_REG)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .st        (st),
      .cnt       (byte_cnt),
      .dir_q     (dir_q),
      .mv        (mv),
      .dma_din   (dma_din),
      .buf_rdata (buf_rdata),
      .buf_addr  (buf_addr),
      .buf_we    (buf_we),
      .buf_wdata (buf_wdata),
      .dma_dout  (dma_dout)
   );
endmodule

// File: rtl/epdma_hs_chk.sv
module epdma_hs_chk #(
   parameter int AW  = 6,
   parameter int CAP = 62
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_we,
   input logic          reg_en,
   input logic          dreq,
   input logic          en_o,
   input logic          done_o,
   input logic          term_o,
   input logic          burst_q,
   input logic          dack_s,
   input logic          eot_hit,
   input logic          mv,
   input logic [AW-1:0] buf_addr,
   input logic [AW-1:0] byte_cnt
);
   AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      dreq |-> en_o); // R1
   AST_SINGLE_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (!burst_q && !dack_s) |=> !dreq); // R3
   AST_EOT_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      eot_hit |=> !dreq); // R5
   AST_STOP_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !reg_en) |=> (!dreq && !en_o)); // R6
   AST_HDR_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
      dreq |-> (buf_addr >= AW'(2))); // R7
   AST_ONE_BYTE_PER_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      mv |=> (byte_cnt == AW'($past(byte_cnt) + 1))); // R9
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && term_o)); // R10
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      byte_cnt <= AW'(CAP)); // R11
endmodule

bind epdma_hs epdma_hs_chk #(.AW(AW), .CAP(CAP)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_we   (reg_we),
   .reg_en   (reg_en),
   .dreq     (dreq),
   .en_o     (en_o),
   .done_o   (done_o),
   .term_o   (term_o),
   .burst_q  (burst_q),
   .dack_s   (dack_s),
   .eot_hit  (eot_hit),
   .mv       (mv),
   .buf_addr (buf_addr),
   .byte_cnt (byte_cnt)
);

// File: tb/epdma_hs_test.sv
`timescale 1ns/1ps
module epdma_hs_test;
   localparam int DEPTH = 64;
   localparam int AW    = $clog2(DEPTH);
   localparam int CAP   = DEPTH - 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0, reg_en = 1'b0, reg_dir = 1'b0, reg_burst = 1'b0;
   logic en_o, done_o, term_o, dreq, buf_we;
   logic [AW-1:0] byte_cnt, buf_addr;
   logic dack_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, eot_n = 1'b1;
   logic [7:0] dma_din = 8'h00;
   logic [7:0] dma_dout, buf_wdata, buf_rdata;

   logic [7:0] mem [DEPTH];
   logic       pre_we = 1'b0;
   logic [AW-1:0] pre_addr = '0;
   logic [7:0] pre_data = 8'h00;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] exp_q [$];
   logic [7:0] got;
   event sample_ev;

   always #2 clk = ~clk;

   epdma_hs #(.DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_en(reg_en),
      .reg_dir(reg_dir), .reg_burst(reg_burst), .en_o(en_o),
      .done_o(done_o), .term_o(term_o), .byte_cnt(byte_cnt), .dreq(dreq),
      .dack_n(dack_n), .rd_n(rd_n), .wr_n(wr_n), .eot_n(eot_n),
      .dma_din(dma_din), .dma_dout(dma_dout), .buf_addr(buf_addr),
      .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
   );

   assign buf_rdata = mem[buf_addr];
   always @(posedge clk) begin
      if (buf_we)      mem[buf_addr] <= buf_wdata;
      else if (pre_we) mem[pre_addr] <= pre_data;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: compare bytes seen on the DMA read side with the scoreboard
   initial begin
      forever begin
         @(sample_ev);
         if (exp_q.size() == 0) chk("R7", "unexpected read byte", 32'(got), 32'hFFFF);
         else chk("R7", "read stream byte (R2 direction)", 32'(got), 32'(exp_q.pop_front()));
      end
   end

   task automatic load(input int a, input logic [7:0] v);
      @(negedge clk); pre_we = 1'b1; pre_addr = AW'(a); pre_data = v;
      @(negedge clk); pre_we = 1'b0;
   endtask

   task automatic enable(input logic dir, input logic burst);
      @(negedge clk); reg_we = 1'b1; reg_en = 1'b1; reg_dir = dir; reg_burst = burst;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic dma_byte(input logic is_wr, input logic with_eot,
                           input logic [7:0] wv, input int mid_exp, input string req);
      int w = 0;
      while (!dreq && w < 40) begin @(negedge clk); w++; end
      chk(req, "request present before ack", 32'(dreq), 32'd1);
      dack_n = 1'b0;
      repeat (2) @(negedge clk);
      if (is_wr) begin wr_n = 1'b0; dma_din = wv; end
      else rd_n = 1'b0;
      if (with_eot) eot_n = 1'b0;
      repeat (4) @(negedge clk);
      if (!is_wr) begin got = dma_dout; ->sample_ev; end
      if (mid_exp >= 0) chk(req, "request during ack", 32'(dreq), 32'(mid_exp));
      rd_n = 1'b1; wr_n = 1'b1;
      repeat (5) @(negedge clk);
      dack_n = 1'b1; eot_n = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic check_written(input string req);
      int k = 0;
      while (exp_q.size() > 0) begin
         chk(req, "stored payload byte", 32'(mem[2+k]), 32'(exp_q.pop_front()));
         k++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset dreq", 32'(dreq), 0);
      chk("R1", "reset enable", 32'(en_o), 0);
      chk("R10", "reset done", 32'(done_o), 0);
      chk("R10", "reset term", 32'(term_o), 0);

      // read, single-cycle, length 5
      load(0, 8'hA5); load(1, 8'd5);
      for (int i = 0; i < 5; i++) load(2 + i, 8'(8'h30 + i * 7));
      enable(1'b0, 1'b0);
      chk("R1", "enable readback", 32'(en_o), 1);
      for (int i = 0; i < 5; i++) begin
         exp_q.push_back(mem[2 + i]);
         dma_byte(1'b0, 1'b0, 8'h00, 0, "R3");
      end
      chk("R7", "read done flag", 32'(done_o), 1);
      chk("R7", "read enable cleared", 32'(en_o), 0);
      chk("R7", "read request low", 32'(dreq), 0);
      chk("R9", "read byte count", 32'(byte_cnt), 5);
      chk("R10", "term after count end", 32'(term_o), 0);

      // read, burst, length 4
      load(1, 8'd4);
      for (int i = 0; i < 4; i++) load(2 + i, 8'(8'hE0 ^ (i * 3)));
      enable(1'b0, 1'b1);
      chk("R10", "done cleared by enable", 32'(done_o), 0);
      for (int i = 0; i < 4; i++) begin
         exp_q.push_back(mem[2 + i]);
         dma_byte(1'b0, 1'b0, 8'h00, 1, "R4");
      end
      chk("R4", "burst read done", 32'(done_o), 1);
      chk("R9", "burst byte count", 32'(byte_cnt), 4);

      // read, zero length
      load(1, 8'd0);
      enable(1'b0, 1'b0);
      repeat (8) @(negedge clk);
      chk("R7", "zero length done", 32'(done_o), 1);
      chk("R7", "zero length enable", 32'(en_o), 0);
      chk("R7", "zero length request", 32'(dreq), 0);

      // write, single-cycle, 3 bytes, EOT on the last
      enable(1'b1, 1'b0);
      for (int i = 0; i < 3; i++) begin
         exp_q.push_back(8'(8'hC1 + i));
         dma_byte(1'b1, i == 2, 8'(8'hC1 + i), 0, "R3");
      end
      chk("R5", "term after EOT", 32'(term_o), 1);
      chk("R10", "done after EOT", 32'(done_o), 0);
      chk("R5", "enable after EOT", 32'(en_o), 0);
      check_written("R8");
      chk("R8", "length byte", 32'(mem[1]), 3);
      chk("R8", "status byte", 32'(mem[0]), 32'h01);

      // write, burst, EOT on second byte: request must fall
      enable(1'b1, 1'b1);
      chk("R10", "term cleared by enable", 32'(term_o), 0);
      exp_q.push_back(8'h11); dma_byte(1'b1, 1'b0, 8'h11, 1, "R4");
      exp_q.push_back(8'h22); dma_byte(1'b1, 1'b1, 8'h22, 0, "R5");
      chk("R5", "burst term", 32'(term_o), 1);
      check_written("R2");
      chk("R8", "burst length byte", 32'(mem[1]), 2);

      // write, EOT without ack ignored, then CPU stop
      enable(1'b1, 1'b1);
      exp_q.push_back(8'h5C); dma_byte(1'b1, 1'b0, 8'h5C, 1, "R4");
      eot_n = 1'b0;
      repeat (6) @(negedge clk);
      chk("R5", "unqualified EOT request", 32'(dreq), 1);
      chk("R5", "unqualified EOT term", 32'(term_o), 0);
      eot_n = 1'b1;
      @(negedge clk); reg_we = 1'b1; reg_en = 1'b0;
      @(negedge clk); reg_we = 1'b0;
      chk("R6", "request after stop", 32'(dreq), 0);
      chk("R6", "enable after stop", 32'(en_o), 0);
      repeat (5) @(negedge clk);
      check_written("R8");
      chk("R8", "stop length byte", 32'(mem[1]), 1);
      chk("R8", "stop status byte", 32'(mem[0]), 32'h01);

      // write, burst, to capacity
      mem[0] = 8'h00;
      enable(1'b1, 1'b1);
      for (int i = 0; i < CAP; i++) begin
         exp_q.push_back(8'(i ^ 8'h5A));
         dma_byte(1'b1, 1'b0, 8'(i ^ 8'h5A), 1, "R11");
      end
      chk("R11", "capacity done", 32'(done_o), 1);
      chk("R11", "capacity enable", 32'(en_o), 0);
      chk("R11", "capacity request", 32'(dreq), 0);
      chk("R9", "capacity count", 32'(byte_cnt), 32'(CAP));
      check_written("R11");
      chk("R11", "capacity length byte", 32'(mem[1]), 32'(CAP));

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule